// File: doc/BRIEF.md
# Asynchronous Serial Port with Sticky Status

This block is a full-duplex asynchronous serial port. Software talks to it through a small synchronous register port with a two-bit address, a write enable, a read strobe and 16-bit data. Three registers are visible: a data location, a status word and a control word. Writing the data location loads a one-word transmit holding buffer. Reading it returns the last word that was received.

On the transmit side, a word moves from the holding buffer into a shift register on the next oversampling tick once the shifter is idle. It then goes out least significant bit first. The frame is a low start bit, the data bits, an optional parity bit and a high stop bit. On the receive side, the incoming line is synchronised and oversampled 16 times per bit. Each bit is sampled near its centre. A completed word is moved into a one-word receive buffer.

The status word combines live flags with sticky flags. Transmitter-empty and holding-empty are live. Data-ready is set by hardware and cleared only by reading the data location. The break, framing, parity and overrun flags stay set until software writes 0 to them. A level transmit-ready request is asserted while its enable is set and the holding buffer is free. A break request output follows the sticky break flag. The baud rate is fixed by a clock-divider parameter.

Top module: `sercom_port`

## Requirements
- R1: After reset the status word reads 0x0060, the control word reads 0x0000, the serial output is high, and both request outputs are low.
- R2: Status bits 15..7 always read 0. Control bits 15..12 always read 0 and cannot be written. Address 0 is data, 1 is status, 2 is control, and 3 reads 0.
- R3: Status bit 5 (holding-empty) is 1 exactly when the holding buffer is free. Status bit 6 (transmitter-empty) is 1 only when both the holding buffer and the shifter are idle. A data write while the holding buffer is full is ignored.
- R4: A transmitted frame is a low start bit, then the data bits LSB first, then a parity bit when enabled, then a high stop bit, each lasting 16 ticks. Control bit 0 enables parity. Control bit 1 selects odd parity when 1 and even parity when 0.
- R5: The transmit-ready request is high exactly while control bit 11 is 1 and the holding buffer is free.
- R6: A received word that ends with a high stop bit is loaded into the receive buffer and sets status bit 4. Reading the data location returns the word and clears bit 4.
- R7: A word that arrives while bit 4 is still 1 replaces the buffered word and sets status bit 0.
- R8: With parity enabled, a received parity bit that does not match the selected sense sets status bit 1. With parity disabled, no parity bit is expected.
- R9: A low line at the stop-bit sample of a frame that is not all-zero sets status bit 2. The word is still loaded.
- R10: A line held low through the whole frame, including the stop sample, sets status bit 3 and the break request. No word is loaded and status bit 4 does not change.
- R11: Writing the status word clears each of bits 3..0 where the written bit is 0 and keeps it where the written bit is 1. A hardware set in the same cycle wins over the clear.
- R12: A start bit that is high again at its mid-bit sample is rejected. No flag changes, and the receiver accepts the next valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| arst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write enable |
| rd_stb_i | input | 1 | Register read strobe; data appears on rdata_o one cycle later |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| txd_o | output | 1 | Serial transmit line, idle high |
| rxd_i | input | 1 | Serial receive line, asynchronous |
| tx_irq_o | output | 1 | Level transmit-ready request |
| brk_irq_o | output | 1 | Break request, follows the sticky break flag |

## Verification
The assertions take for granted that the receive line is held for whole bit periods that match the divider, give or take a few clocks. They also assume the reset input is asserted from time zero. The overrun and read-clear properties assume the data-location read does not fall in the same cycle as a word arrival. The stimulus keeps within these assumptions. It drives every receive frame with exact bit periods of 16 ticks from a clock that is common with the design. It leaves two idle bit times before any register read. It deliberately breaks the line rules only in the framing, break and short-glitch cases that the requirements name.

// File: rtl/sercom_pkg.sv
package sercom_pkg;
  // status bit positions
  localparam int ST_OER  = 0;
  localparam int ST_PER  = 1;
  localparam int ST_FER  = 2;
  localparam int ST_BRK  = 3;
  localparam int ST_RDR  = 4;
  localparam int ST_THRE = 5;
  localparam int ST_TEMT = 6;

  // control bit positions
  localparam int CT_PAR_EN  = 0;
  localparam int CT_PAR_ODD = 1;
  localparam int CT_TXIE    = 11;
  localparam int CT_W       = 12;

  // register addresses
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_CTRL = 2'd2;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP,
    RX_WAIT
  } rx_state_t;
endpackage

// File: rtl/sercom_baud.sv
module sercom_baud #(
  parameter int CLK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLK_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              load_req_i,
  input  logic [DATA_W-1:0] load_data_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic              load_ack_o,
  output logic              busy_o,
  output logic              txd_o
);
  localparam int FW = DATA_W + 3;
  localparam int NW = $clog2(FW + 1);
  localparam int OW = $clog2(OSR);
  localparam logic [OW-1:0] PH_LAST = OW'(OSR - 1);

  logic [FW-1:0] sh_q, sh_d;
  logic [NW-1:0] left_q, left_d;
  logic [OW-1:0] ph_q, ph_d;
  logic          busy_q, busy_d;
  logic          par_bit;
  logic [FW-1:0] frame;

  always_comb begin
    par_bit = par_odd_i ? ~(^load_data_i) : (^load_data_i);
    frame   = {1'b1, (par_en_i ? par_bit : 1'b1), load_data_i, 1'b0};
  end

  always_comb begin
    sh_d       = sh_q;
    left_d     = left_q;
    ph_d       = ph_q;
    busy_d     = busy_q;
    load_ack_o = 1'b0;
    if (!busy_q) begin
      if (tick_i && load_req_i) begin
        sh_d       = frame;
        left_d     = par_en_i ? NW'(FW) : NW'(FW - 1);
        ph_d       = '0;
        busy_d     = 1'b1;
        load_ack_o = 1'b1;
      end
    end else if (tick_i) begin
      if (ph_q == PH_LAST) begin
        ph_d   = '0;
        sh_d   = {1'b1, sh_q[FW-1:1]};
        left_d = left_q - 1'b1;
        if (left_q == NW'(1)) busy_d = 1'b0;
      end else begin
        ph_d = ph_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      left_q <= left_d;
      ph_q   <= ph_d;
      busy_q <= busy_d;
    end
  end

  assign busy_o = busy_q;
  assign txd_o  = busy_q ? sh_q[0] : 1'b1;

  AST_START_BIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy_q && !$past(busy_q)) |-> !txd_o); // R4

  AST_IDLE_WITHOUT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_q && !load_ack_o) |=> !busy_q); // R3
endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
  import sercom_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  output logic [DATA_W-1:0] word_o,
  output logic              done_o,
  output logic              fer_o,
  output logic              per_o,
  output logic              brk_o
);
  localparam int OW = $clog2(OSR);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [OW-1:0] PH_LAST = OW'(OSR - 1);
  localparam logic [OW-1:0] PH_HALF = OW'(OSR / 2 - 1);
  localparam logic [IW-1:0] IDX_LAST = IW'(DATA_W - 1);

  rx_state_t         st_q, st_d;
  logic [OW-1:0]     ph_q, ph_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              par_q, par_d;
  logic              zero_q, zero_d;
  logic              sample;
  logic              par_exp;
  logic              par_bad;

  assign sample  = tick_i && (ph_q == PH_LAST);
  assign par_exp = par_odd_i ? ~(^sh_q) : (^sh_q);
  assign par_bad = par_en_i && (par_q != par_exp);

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    idx_d  = idx_q;
    sh_d   = sh_q;
    par_d  = par_q;
    zero_d = zero_q;
    done_o = 1'b0;
    fer_o  = 1'b0;
    per_o  = 1'b0;
    brk_o  = 1'b0;
    if (tick_i && (st_q inside {RX_DATA, RX_PAR, RX_STOP}) && !sample)
      ph_d = ph_q + 1'b1;
    case (st_q)
      RX_IDLE: begin
        if (tick_i && !rxd_i) begin
          st_d = RX_START;
          ph_d = '0;
        end
      end
      RX_START: begin
        if (tick_i) begin
          if (ph_q == PH_HALF) begin
            ph_d = '0;
            if (!rxd_i) begin
              st_d   = RX_DATA;
              idx_d  = '0;
              zero_d = 1'b1;
            end else begin
              st_d = RX_IDLE;
            end
          end else begin
            ph_d = ph_q + 1'b1;
          end
        end
      end
      RX_DATA: begin
        if (sample) begin
          ph_d = '0;
          sh_d = {rxd_i, sh_q[DATA_W-1:1]};
          if (rxd_i) zero_d = 1'b0;
          if (idx_q == IDX_LAST) st_d = par_en_i ? RX_PAR : RX_STOP;
          else                   idx_d = idx_q + 1'b1;
        end
      end
      RX_PAR: begin
        if (sample) begin
          ph_d  = '0;
          par_d = rxd_i;
          if (rxd_i) zero_d = 1'b0;
          st_d = RX_STOP;
        end
      end
      RX_STOP: begin
        if (sample) begin
          ph_d = '0;
          if (rxd_i) begin
            done_o = 1'b1;
            per_o  = par_bad;
            st_d   = RX_IDLE;
          end else begin
            if (zero_q) begin
              brk_o = 1'b1;
            end else begin
              done_o = 1'b1;
              fer_o  = 1'b1;
              per_o  = par_bad;
            end
            st_d = RX_WAIT;
          end
        end
      end
      RX_WAIT: begin
        if (rxd_i) st_d = RX_IDLE;
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      idx_q  <= '0;
      sh_q   <= '0;
      par_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      idx_q  <= idx_d;
      sh_q   <= sh_d;
      par_q  <= par_d;
      zero_q <= zero_d;
    end
  end

  assign word_o = sh_q;

  AST_BREAK_NOT_WORD: assert property (@(posedge clk_i) disable iff (!rst_n)
    brk_o |-> !done_o); // R10

  AST_GLITCH_REJECTED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == RX_START && tick_i && ph_q == PH_HALF && rxd_i) |=> (st_q == RX_IDLE)); // R12

  AST_FER_NEEDS_DONE: assert property (@(posedge clk_i) disable iff (!rst_n)
    fer_o |-> done_o); // R9
endmodule

// File: rtl/sercom_port.sv
module sercom_port
  import sercom_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CLK_DIV = 4,
  parameter int OSR     = 16
) (
  input  logic        clk_i,
  input  logic        arst_n_i,
  input  logic [1:0]  addr_i,
  input  logic        wr_en_i,
  input  logic        rd_stb_i,
  input  logic [15:0] wdata_i,
  output logic [15:0] rdata_o,
  output logic        txd_o,
  input  logic        rxd_i,
  output logic        tx_irq_o,
  output logic        brk_irq_o
);
  localparam int RW = 16;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge arst_n_i) begin
    if (!arst_n_i) rs_q <= 2'b00;
    else           rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n = rs_q[1];

  // receive line synchroniser
  logic [1:0] rxs_q;
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) rxs_q <= 2'b11;
    else        rxs_q <= {rxs_q[0], rxd_i};
  end

  logic              tick;
  logic              tx_ack;
  logic              tx_busy;
  logic [DATA_W-1:0] rx_word;
  logic              rx_done, rx_fer, rx_per, rx_brk;

  logic [CT_W-1:0]   ctl_q, ctl_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              hold_full_q, hold_full_d;
  logic [DATA_W-1:0] rbuf_q, rbuf_d;
  logic              rdr_q, rdr_d;
  logic [3:0]        err_q, err_d;
  logic [RW-1:0]     rdata_q, rdata_d;

  logic wr_data, wr_stat, wr_ctrl, rd_data;
  logic thre, temt;
  logic [RW-1:0] status;
  logic [3:0]    err_set;
  logic          unused_wbits;

  sercom_baud #(.CLK_DIV(CLK_DIV)) u_baud (
    .clk_i (clk_i),
    .rst_n (rst_n),
    .tick_o(tick)
  );

  sercom_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .tick_i     (tick),
    .load_req_i (hold_full_q),
    .load_data_i(hold_q),
    .par_en_i   (ctl_q[CT_PAR_EN]),
    .par_odd_i  (ctl_q[CT_PAR_ODD]),
    .load_ack_o (tx_ack),
    .busy_o     (tx_busy),
    .txd_o      (txd_o)
  );

  sercom_rx #(.DATA_W(DATA_W), .OSR(OSR)) u_rx (
    .clk_i    (clk_i),
    .rst_n    (rst_n),
    .tick_i   (tick),
    .rxd_i    (rxs_q[1]),
    .par_en_i (ctl_q[CT_PAR_EN]),
    .par_odd_i(ctl_q[CT_PAR_ODD]),
    .word_o   (rx_word),
    .done_o   (rx_done),
    .fer_o    (rx_fer),
    .per_o    (rx_per),
    .brk_o    (rx_brk)
  );

  assign wr_data = wr_en_i && (addr_i == A_DATA);
  assign wr_stat = wr_en_i && (addr_i == A_STAT);
  assign wr_ctrl = wr_en_i && (addr_i == A_CTRL);
  assign rd_data = rd_stb_i && (addr_i == A_DATA);

  assign thre = !hold_full_q;
  assign temt = !hold_full_q && !tx_busy;

  always_comb begin
    status          = '0;
    status[ST_TEMT] = temt;
    status[ST_THRE] = thre;
    status[ST_RDR]  = rdr_q;
    status[ST_BRK]  = err_q[ST_BRK];
    status[ST_FER]  = err_q[ST_FER];
    status[ST_PER]  = err_q[ST_PER];
    status[ST_OER]  = err_q[ST_OER];
  end

  always_comb begin
    err_set         = '0;
    err_set[ST_OER] = rx_done && rdr_q && !rd_data;
    err_set[ST_PER] = rx_per;
    err_set[ST_FER] = rx_fer;
    err_set[ST_BRK] = rx_brk;
  end

  always_comb begin
    ctl_d       = ctl_q;
    hold_d      = hold_q;
    hold_full_d = hold_full_q;
    rbuf_d      = rbuf_q;
    rdr_d       = rdr_q;
    rdata_d     = rdata_q;

    if (wr_ctrl) ctl_d = wdata_i[CT_W-1:0];

    if (tx_ack) hold_full_d = 1'b0;
    if (wr_data && !hold_full_q) begin
      hold_d      = wdata_i[DATA_W-1:0];
      hold_full_d = 1'b1;
    end

    if (rd_data) rdr_d = 1'b0;
    if (rx_done) begin
      rbuf_d = rx_word;
      rdr_d  = 1'b1;
    end

    err_d = (wr_stat ? (err_q & wdata_i[3:0]) : err_q) | err_set;

    if (rd_stb_i) begin
      case (addr_i)
        A_DATA:  rdata_d = RW'(rbuf_q);
        A_STAT:  rdata_d = status;
        A_CTRL:  rdata_d = RW'(ctl_q);
        default: rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q       <= '0;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      rbuf_q      <= '0;
      rdr_q       <= 1'b0;
      err_q       <= '0;
      rdata_q     <= '0;
    end else begin
      ctl_q       <= ctl_d;
      hold_q      <= hold_d;
      hold_full_q <= hold_full_d;
      rbuf_q      <= rbuf_d;
      rdr_q       <= rdr_d;
      err_q       <= err_d;
      rdata_q     <= rdata_d;
    end
  end

  assign rdata_o      = rdata_q;
  assign tx_irq_o     = ctl_q[CT_TXIE] && thre;
  assign brk_irq_o    = err_q[ST_BRK];
  assign unused_wbits = ^wdata_i[15:CT_W];

  AST_READ_CLEARS_RDR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_data && !rx_done) |=> !rdr_q); // R6

  AST_OVERRUN_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_done && rdr_q && !rd_data) |=> err_q[ST_OER]); // R7

  AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_n)
    rx_fer |=> err_q[ST_FER]); // R11

  AST_NO_IRQ_WHEN_FULL: assert property (@(posedge clk_i) disable iff (!rst_n)
    hold_full_q |-> !tx_irq_o); // R5

  AST_BREAK_KEEPS_RDR: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rx_brk && !rd_data) |=> (rdr_q == $past(rdr_q))); // R10

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_data && hold_full_q && !tx_ack) |=> (hold_q == $past(hold_q))); // R3
endmodule

// File: tb/sercom_port_tb.sv
module sercom_port_tb;
  localparam int CLK_DIV = 4;
  localparam int BIT     = 16 * CLK_DIV;

  logic        clk;
  logic        arst_n;
  logic [1:0]  addr;
  logic        wr_en;
  logic        rd_stb;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        txd;
  logic        rxd;
  logic        tx_irq;
  logic        brk_irq;

  int checks;
  int failures;
  int mon_cnt;
  bit done_flag;
  logic [9:0] sb_q[$];   // {par_en, par_odd, data}

  sercom_port #(.DATA_W(8), .CLK_DIV(CLK_DIV), .OSR(16)) u_dut (
    .clk_i    (clk),
    .arst_n_i (arst_n),
    .addr_i   (addr),
    .wr_en_i  (wr_en),
    .rd_stb_i (rd_stb),
    .wdata_i  (wdata),
    .rdata_o  (rdata),
    .txd_o    (txd),
    .rxd_i    (rxd),
    .tx_irq_o (tx_irq),
    .brk_irq_o(brk_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_stb = 1'b1;
    @(negedge clk);
    rd_stb = 1'b0;
    d = rdata;
  endtask

  // driver side of the transmit scoreboard
  task automatic send_tx(input logic [7:0] d, input logic pe, input logic po);
    sb_q.push_back({pe, po, d});
    bus_wr(2'd0, {8'h00, d});
  endtask

  task automatic drive_frame(input logic [7:0] d, input logic pe, input logic po,
                             input logic flip, input logic stop);
    @(negedge clk);
    rxd = 1'b0;
    repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      repeat (BIT) @(negedge clk);
    end
    if (pe) begin
      rxd = (^d) ^ po ^ flip;
      repeat (BIT) @(negedge clk);
    end
    rxd = stop;
    repeat (BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
  endtask

  // monitor side of the transmit scoreboard
  initial begin
    logic [7:0] d;
    logic       p, s, st, pe, po;
    logic [9:0] it;
    mon_cnt = 0;
    wait (done_flag == 1'b0 && arst_n === 1'b1);
    forever begin
      @(negedge clk);
      if (txd === 1'b0) begin
        pe = 1'b0; po = 1'b0;
        if (sb_q.size() != 0) begin
          pe = sb_q[0][9];
          po = sb_q[0][8];
        end
        repeat (BIT / 2) @(negedge clk);
        st = txd;
        for (int i = 0; i < 8; i++) begin
          repeat (BIT) @(negedge clk);
          d[i] = txd;
        end
        p = 1'b0;
        if (pe) begin
          repeat (BIT) @(negedge clk);
          p = txd;
        end
        repeat (BIT) @(negedge clk);
        s = txd;
        chk("R4 start bit", {15'd0, st}, 16'h0000);
        chk("R4 stop bit", {15'd0, s}, 16'h0001);
        if (sb_q.size() == 0) begin
          chk("R3 unexpected frame", {8'h00, d}, 16'hFFFF);
        end else begin
          it = sb_q.pop_front();
          chk("R4 data", {8'h00, d}, {8'h00, it[7:0]});
          if (pe) chk("R4 parity", {15'd0, p}, {15'd0, (^it[7:0]) ^ po});
        end
        mon_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    checks = 0; failures = 0; done_flag = 1'b0;
    arst_n = 1'b0; addr = 2'd0; wr_en = 1'b0; rd_stb = 1'b0; wdata = '0; rxd = 1'b1;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    bus_rd(2'd1, v); chk("R1 status", v, 16'h0060);
    bus_rd(2'd2, v); chk("R1 control", v, 16'h0000);
    chk("R1 txd idle", {15'd0, txd}, 16'h0001);
    chk("R1 tx_irq", {15'd0, tx_irq}, 16'h0000);
    chk("R1 brk_irq", {15'd0, brk_irq}, 16'h0000);

    // R2 reserved bits
    bus_wr(2'd2, 16'hFFFF);
    bus_rd(2'd2, v); chk("R2 control reserved", v, 16'h0FFF);
    bus_wr(2'd2, 16'h0000);
    bus_wr(2'd1, 16'hFFFF);
    bus_rd(2'd1, v); chk("R2 status reserved", v, 16'h0060);
    bus_rd(2'd3, v); chk("R2 unused address", v, 16'h0000);

    // R5 transmit-ready request
    bus_wr(2'd2, 16'h0800);
    chk("R5 irq with empty holding", {15'd0, tx_irq}, 16'h0001);

    // R3/R4 transmit path
    send_tx(8'hA5, 1'b0, 1'b0);
    chk("R5 irq low while holding full", {15'd0, tx_irq}, 16'h0000);
    repeat (2 * BIT) @(negedge clk);
    bus_rd(2'd1, v); chk("R3 shifting, holding free", v, 16'h0020);
    chk("R5 irq back high", {15'd0, tx_irq}, 16'h0001);
    send_tx(8'h3C, 1'b0, 1'b0);
    bus_rd(2'd1, v); chk("R3 holding full", v, 16'h0000);
    bus_wr(2'd0, 16'h0077);   // ignored: holding full
    repeat (25 * BIT) @(negedge clk);
    bus_rd(2'd1, v); chk("R3 all empty", v, 16'h0060);

    // R4 parity on transmit
    bus_wr(2'd2, 16'h0801);
    send_tx(8'h5A, 1'b1, 1'b0);
    repeat (13 * BIT) @(negedge clk);
    bus_wr(2'd2, 16'h0803);
    send_tx(8'h0F, 1'b1, 1'b1);
    repeat (13 * BIT) @(negedge clk);
    bus_wr(2'd2, 16'h0000);
    chk("R5 irq disabled", {15'd0, tx_irq}, 16'h0000);

    // R6 receive and read-clear
    drive_frame(8'h96, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, v); chk("R6 data ready", v, 16'h0070);
    bus_rd(2'd0, v); chk("R6 data", v, 16'h0096);
    bus_rd(2'd1, v); chk("R6 ready cleared", v, 16'h0060);

    // R7 overrun, R11 write-1 keeps, write-0 clears
    drive_frame(8'h11, 1'b0, 1'b0, 1'b0, 1'b1);
    drive_frame(8'h22, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, v); chk("R7 overrun", v, 16'h0071);
    bus_rd(2'd0, v); chk("R7 newest word", v, 16'h0022);
    bus_wr(2'd1, 16'h000F);
    bus_rd(2'd1, v); chk("R11 write one keeps", v, 16'h0061);
    bus_wr(2'd1, 16'h0000);
    bus_rd(2'd1, v); chk("R11 write zero clears", v, 16'h0060);

    // R8 parity on receive
    bus_wr(2'd2, 16'h0001);
    drive_frame(8'h35, 1'b1, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, v); chk("R8 even parity good", v, 16'h0070);
    bus_rd(2'd0, v); chk("R8 data", v, 16'h0035);
    drive_frame(8'h35, 1'b1, 1'b0, 1'b1, 1'b1);
    bus_rd(2'd1, v); chk("R8 even parity bad", v, 16'h0072);
    bus_rd(2'd0, v);
    bus_wr(2'd1, 16'h0000);
    bus_wr(2'd2, 16'h0003);
    drive_frame(8'h35, 1'b1, 1'b1, 1'b0, 1'b1);
    bus_rd(2'd1, v); chk("R8 odd parity good", v, 16'h0070);
    bus_rd(2'd0, v);
    bus_wr(2'd2, 16'h0000);

    // R9 framing error
    drive_frame(8'h81, 1'b0, 1'b0, 1'b0, 1'b0);
    bus_rd(2'd1, v); chk("R9 framing", v, 16'h0074);
    bus_rd(2'd0, v); chk("R9 word kept", v, 16'h0081);
    bus_wr(2'd1, 16'h0000);

    // R10 break
    @(negedge clk); rxd = 1'b0;
    repeat (11 * BIT) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    bus_rd(2'd1, v); chk("R10 break, no word", v, 16'h0068);
    chk("R10 brk_irq", {15'd0, brk_irq}, 16'h0001);
    bus_wr(2'd1, 16'h0000);
    bus_rd(2'd1, v); chk("R11 break cleared", v, 16'h0060);
    chk("R10 brk_irq cleared", {15'd0, brk_irq}, 16'h0000);

    // R12 glitch rejection
    @(negedge clk); rxd = 1'b0;
    repeat (3 * CLK_DIV) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BIT) @(negedge clk);
    bus_rd(2'd1, v); chk("R12 glitch ignored", v, 16'h0060);
    drive_frame(8'hC3, 1'b0, 1'b0, 1'b0, 1'b1);
    bus_rd(2'd1, v); chk("R12 next frame accepted", v, 16'h0070);
    bus_rd(2'd0, v); chk("R12 next frame data", v, 16'h00C3);

    // scoreboard drained
    chk("R3 frames sent", 16'(mon_cnt), 16'd4);
    chk("R4 queue empty", 16'(sb_q.size()), 16'd0);

    if (!done_flag) begin
      done_flag = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule